// File: doc/BRIEF.md
# Post-Sleep Timer Resynchronization Calculator

A fast free-running timer (32 MHz tick) stops while the chip sleeps. During sleep, only a 24-bit sleep timer on a 32 kHz clock keeps counting. On wake-up, this block works out where the fast timer would have been had it kept running. It also works out how many times that timer would have wrapped. From the results it produces a new timer count and a new value for the overflow counter that sits above the timer.

Software or a power controller sets the operands and pulses `start_i`. The operands are the current and saved sleep-timer readings, the saved fast-timer count and overflow count, and the timer period and overflow period. The block samples the operands on the start edge. It scales the elapsed slow ticks by 976.5625, rounding to the nearest integer, and adds the saved count and a fixed wake-up overhead of 86 ticks. The sum then goes through two passes of a bit-serial restoring divider. The first pass divides by the timer period. The second reduces the stored overflow count plus the quotient of the first pass, modulo the overflow period. When both passes finish, `done_o` pulses for one cycle and the two result outputs update.

Top module: `sleep_resync_calc`

## Requirements
- R1: The elapsed sleep ticks are (`st_now_i` − `st_saved_i`) mod 2^24. A difference of zero counts as 2^24 ticks, so a full wrap of the sleep timer is covered.
- R2: The total fast-tick count is C = round(elapsed × 976.5625) + `tmr_saved_i` + 86. An exact half rounds up.
- R3: After a successful run, `timer_o` equals C mod `period_i`.
- R4: After a successful run, `ovf_cnt_o` equals (`ovf_saved_i` + floor(C / `period_i`)) mod `ovf_period_i`.
- R5: Call the edge that samples an accepted start edge 0. `done_o` is high for exactly one cycle, following edge 85 on a successful run and edge 1 on an error run.
- R6: `busy_o` is high from edge 0 up to the edge that raises `done_o`. It is low while `done_o` is high, and it never falls without `done_o`.
- R7: A `start_i` pulse while `busy_o` is high is ignored. It adds no `done_o` pulse and does not change the results or the timing of the run in progress.
- R8: If `period_i` or `ovf_period_i` is zero, `done_o` rises with `err_o`, and `timer_o` and `ovf_cnt_o` keep their previous values.
- R9: After reset, `busy_o`, `done_o` and `err_o` are low, and `timer_o` and `ovf_cnt_o` are zero.
- R10: `err_o` is never high without `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled when idle |
| st_now_i | input | 24 | Sleep-timer reading at wake-up |
| st_saved_i | input | 24 | Sleep-timer reading stored at sleep entry |
| tmr_saved_i | input | 16 | Fast-timer count stored at sleep entry |
| ovf_saved_i | input | 24 | Overflow count stored at sleep entry |
| period_i | input | 16 | Fast-timer period |
| ovf_period_i | input | 24 | Overflow counter period |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Zero period seen, valid with done_o |
| timer_o | output | 16 | New fast-timer count |
| ovf_cnt_o | output | 24 | New overflow count |

## Verification
The checker compares `timer_o` and `ovf_cnt_o` with the live `period_i` and `ovf_period_i` in the cycle of `done_o`. That comparison is valid only if the caller holds the period operands unchanged from start until done. The saved overflow count is also taken to be below its period. The bench keeps every operand steady for the whole run, including the run in which it sends an extra start pulse while busy, and it draws saved overflow counts below their periods. It covers sleep-timer wrap, equal readings, an exact half-tick rounding, unit and maximal periods, and both zero-period errors.

// File: rtl/resync_pkg.sv
package resync_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCALE,
    ST_DIV_T,
    ST_DIV_O
  } resync_state_e;
endpackage

// File: rtl/sleep_tick_scaler.sv
module sleep_tick_scaler #(
  parameter int ST_W        = 24,
  parameter int TMR_W       = 16,
  parameter int CNT_W       = 40,
  parameter int RATIO_NUM   = 15625,
  parameter int RATIO_SHIFT = 4,
  parameter int OVERHEAD    = 86
) (
  input  logic [ST_W-1:0]  st_now_i,
  input  logic [ST_W-1:0]  st_saved_i,
  input  logic [TMR_W-1:0] tmr_saved_i,
  output logic [CNT_W-1:0] ticks_o
);
  logic [ST_W-1:0]  delta;
  logic [CNT_W-1:0] elapsed;
  logic [CNT_W-1:0] prod;
  logic [CNT_W-1:0] scaled;

  always_comb begin
    delta   = st_now_i - st_saved_i;
    // zero difference means the sleep timer went all the way round
    elapsed = (delta == '0) ? (CNT_W'(1) << ST_W) : CNT_W'(delta);
    prod    = elapsed * CNT_W'(RATIO_NUM);
  end

  generate
    if (RATIO_SHIFT > 0) begin : g_round
      assign scaled = (prod + (CNT_W'(1) << (RATIO_SHIFT - 1))) >> RATIO_SHIFT;
    end else begin : g_exact
      assign scaled = prod;
    end
  endgenerate

  assign ticks_o = scaled + CNT_W'(tmr_saved_i) + CNT_W'(OVERHEAD);
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
  parameter int DIVIDEND_W = 41,
  parameter int DIVISOR_W  = 24
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [DIVIDEND_W-1:0] dividend_i,
  input  logic [DIVISOR_W-1:0]  divisor_i,
  output logic                  done_o,
  output logic [DIVIDEND_W-1:0] quot_o,
  output logic [DIVISOR_W-1:0]  rem_o
);
  localparam int CW = $clog2(DIVIDEND_W + 1);

  logic [DIVIDEND_W-1:0] quot_q;
  logic [DIVISOR_W-1:0]  rem_q;
  logic [DIVISOR_W-1:0]  dvs_q;
  logic [CW-1:0]         cnt_q;
  logic                  run_q;
  logic [DIVISOR_W:0]    trial;
  logic [DIVISOR_W:0]    diff;
  logic                  fits;

  always_comb begin
    trial = {rem_q, quot_q[DIVIDEND_W-1]};
    diff  = trial - {1'b0, dvs_q};
    fits  = (trial >= {1'b0, dvs_q});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quot_q <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
    end else if (load_i) begin
      quot_q <= dividend_i;
      rem_q  <= '0;
      dvs_q  <= divisor_i;
      cnt_q  <= CW'(DIVIDEND_W);
      run_q  <= 1'b1;
    end else if (run_q) begin
      if (cnt_q != '0) begin
        rem_q  <= fits ? diff[DIVISOR_W-1:0] : trial[DIVISOR_W-1:0];
        quot_q <= {quot_q[DIVIDEND_W-2:0], fits};
        cnt_q  <= cnt_q - CW'(1);
      end else begin
        run_q <= 1'b0;
      end
    end
  end

  assign done_o = run_q && (cnt_q == '0);
  assign quot_o = quot_q;
  assign rem_o  = rem_q;
endmodule

// File: rtl/sleep_resync_calc.sv
module sleep_resync_calc #(
  parameter int ST_W        = 24,
  parameter int TMR_W       = 16,
  parameter int OVF_W       = 24,
  parameter int CNT_W       = 40,
  parameter int RATIO_NUM   = 15625,
  parameter int RATIO_SHIFT = 4,
  parameter int OVERHEAD    = 86
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [ST_W-1:0]  st_now_i,
  input  logic [ST_W-1:0]  st_saved_i,
  input  logic [TMR_W-1:0] tmr_saved_i,
  input  logic [OVF_W-1:0] ovf_saved_i,
  input  logic [TMR_W-1:0] period_i,
  input  logic [OVF_W-1:0] ovf_period_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [TMR_W-1:0] timer_o,
  output logic [OVF_W-1:0] ovf_cnt_o
);
  import resync_pkg::*;

  localparam int DIV_W = CNT_W + 1;
  localparam int REM_W = (TMR_W > OVF_W) ? TMR_W : OVF_W;

  resync_state_e state_q;

  logic [ST_W-1:0]  now_q, saved_q;
  logic [TMR_W-1:0] tsav_q, per_q, tmr_tmp_q, timer_q;
  logic [OVF_W-1:0] osav_q, operiod_q, ovf_q;
  logic             done_q, err_q;

  logic [CNT_W-1:0] ticks;
  logic             div_load, div_done;
  logic [DIV_W-1:0] div_dividend, div_quot;
  logic [REM_W-1:0] div_divisor, div_rem;
  logic             bad_period;

  sleep_tick_scaler #(
    .ST_W(ST_W), .TMR_W(TMR_W), .CNT_W(CNT_W),
    .RATIO_NUM(RATIO_NUM), .RATIO_SHIFT(RATIO_SHIFT), .OVERHEAD(OVERHEAD)
  ) u_scaler (
    .st_now_i   (now_q),
    .st_saved_i (saved_q),
    .tmr_saved_i(tsav_q),
    .ticks_o    (ticks)
  );

  restoring_divider #(.DIVIDEND_W(DIV_W), .DIVISOR_W(REM_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (div_load),
    .dividend_i(div_dividend),
    .divisor_i (div_divisor),
    .done_o    (div_done),
    .quot_o    (div_quot),
    .rem_o     (div_rem)
  );

  assign bad_period = (per_q == '0) || (operiod_q == '0);

  // divider feed: timer period first, then overflow period
  always_comb begin
    div_load     = 1'b0;
    div_dividend = DIV_W'(ticks);
    div_divisor  = REM_W'(per_q);
    if (state_q == ST_SCALE && !bad_period) begin
      div_load = 1'b1;
    end else if (state_q == ST_DIV_T && div_done) begin
      div_load     = 1'b1;
      div_dividend = DIV_W'(div_quot[CNT_W-1:0]) + DIV_W'(osav_q);
      div_divisor  = REM_W'(operiod_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      now_q     <= '0;
      saved_q   <= '0;
      tsav_q    <= '0;
      osav_q    <= '0;
      per_q     <= '0;
      operiod_q <= '0;
      tmr_tmp_q <= '0;
      timer_q   <= '0;
      ovf_q     <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            now_q     <= st_now_i;
            saved_q   <= st_saved_i;
            tsav_q    <= tmr_saved_i;
            osav_q    <= ovf_saved_i;
            per_q     <= period_i;
            operiod_q <= ovf_period_i;
            state_q   <= ST_SCALE;
          end
        end
        ST_SCALE: begin
          if (bad_period) begin
            done_q  <= 1'b1;
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_DIV_T;
          end
        end
        ST_DIV_T: begin
          if (div_done) begin
            tmr_tmp_q <= div_rem[TMR_W-1:0];
            state_q   <= ST_DIV_O;
          end
        end
        ST_DIV_O: begin
          if (div_done) begin
            timer_q <= tmr_tmp_q;
            ovf_q   <= div_rem[OVF_W-1:0];
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign timer_o   = timer_q;
  assign ovf_cnt_o = ovf_q;
endmodule

// File: rtl/resync_checker.sv
module resync_checker #(
  parameter int TMR_W = 16,
  parameter int OVF_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [TMR_W-1:0] period_i,
  input logic [OVF_W-1:0] ovf_period_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic [TMR_W-1:0] timer_o,
  input logic [OVF_W-1:0] ovf_cnt_o
);
  a_r10_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  a_r6_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_busy_ends_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r6_start_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  a_r8_hold_on_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> ($stable(timer_o) && $stable(ovf_cnt_o)));

  a_r3_timer_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (timer_o < period_i));

  a_r4_ovf_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (ovf_cnt_o < ovf_period_i));
endmodule

bind sleep_resync_calc resync_checker #(.TMR_W(TMR_W), .OVF_W(OVF_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .period_i    (period_i),
  .ovf_period_i(ovf_period_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .timer_o     (timer_o),
  .ovf_cnt_o   (ovf_cnt_o)
);

// File: tb/sleep_resync_calc_bench.sv
module sleep_resync_calc_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] st_now_i = '0, st_saved_i = '0, ovf_saved_i = '0, ovf_period_i = '0;
  logic [15:0] tmr_saved_i = '0, period_i = '0;
  logic        busy_o, done_o, err_o;
  logic [15:0] timer_o;
  logic [23:0] ovf_cnt_o;

  int n_chk = 0;
  int n_fail = 0;
  longint exp_t = 0;
  longint exp_o = 0;

  always #2 clk_i = ~clk_i;

  sleep_resync_calc u_sleep_resync_calc (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .st_now_i(st_now_i), .st_saved_i(st_saved_i), .tmr_saved_i(tmr_saved_i),
    .ovf_saved_i(ovf_saved_i), .period_i(period_i), .ovf_period_i(ovf_period_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .timer_o(timer_o), .ovf_cnt_o(ovf_cnt_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_case(input longint now, input longint saved, input longint tv,
                          input longint ov, input longint p, input longint po,
                          input bit poke, input string tag);
    longint el, c, q;
    bit     bad;
    int     lat;
    bad = (p == 0) || (po == 0);
    lat = bad ? 1 : 85;
    // R1: modular elapsed ticks, zero means a full wrap
    el = (now - saved) & 64'hFF_FFFF;
    if (el == 0) el = 64'h100_0000;
    // R2: round to nearest, half up, plus saved count and overhead
    c = ((el * 15625 + 8) >>> 4) + tv + 86;
    if (!bad) begin
      q     = c / p;
      exp_t = c % p;
      exp_o = (ov + q) % po;
    end
    @(negedge clk_i);
    st_now_i = 24'(now); st_saved_i = 24'(saved); tmr_saved_i = 16'(tv);
    ovf_saved_i = 24'(ov); period_i = 16'(p); ovf_period_i = 24'(po);
    start_i = 1'b1;
    for (int k = 0; k <= lat + 2; k++) begin
      @(negedge clk_i);
      if (k == 0) start_i = 1'b0;
      if (poke && k == 10) start_i = 1'b1; // R7 start during busy
      if (poke && k == 11) start_i = 1'b0;
      check(busy_o == (k < lat), {tag, " R6 busy"}, longint'(busy_o), longint'(k < lat));
      check(done_o == (k == lat), {tag, " R5 done timing"}, longint'(done_o), longint'(k == lat));
      if (k == lat) begin
        check(err_o == bad, {tag, " R8 R10 err"}, longint'(err_o), longint'(bad));
        check(longint'(timer_o) == exp_t, {tag, " R3 timer"}, longint'(timer_o), exp_t);
        check(longint'(ovf_cnt_o) == exp_o, {tag, " R4 overflow"}, longint'(ovf_cnt_o), exp_o);
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    check({busy_o, done_o, err_o} == 3'b000, "R9 flags", longint'({busy_o, done_o, err_o}), 0);
    check(timer_o == '0 && ovf_cnt_o == '0, "R9 outputs", longint'(timer_o) + longint'(ovf_cnt_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    run_case(1000, 200, 1234, 5, 10000, 1000, 1'b0, "plain R1 R2");
    run_case(10, 24'hFFFFF0, 0, 0, 16'hFFFF, 24'hFFFFFF, 1'b0, "wrap R1");
    run_case(24'h123456, 24'h123456, 77, 24'hFFFFF, 40000, 24'h100000, 1'b0, "equal R1");
    run_case(8, 0, 0, 0, 16'hFFFF, 24'hFFFFFF, 1'b0, "half R2");
    run_case(500000, 3, 65535, 3, 1, 7, 1'b0, "unit period R3 R4");
    run_case(24'h00A000, 24'h009000, 9000, 12, 321, 97, 1'b1, "busy start R7");
    run_case(5000, 10, 3, 4, 0, 100, 1'b0, "zero period R8");
    run_case(5000, 10, 3, 4, 100, 0, 1'b0, "zero ovf period R8");
    run_case(24'hFFFFFF, 0, 40000, 0, 50000, 1, 1'b0, "ovf period one R4");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule